// File: doc/BRIEF.md
# Non-Retriggerable One-Shot Interval Timer

The block measures out a programmable number of clock cycles after a trigger. A rising edge on the trigger input, seen while the block is idle, latches a 24-bit pulse count and starts a timing interval of exactly that many clock cycles. In the last cycle of the interval the block raises a completion strobe for a single clock. It then returns to idle and will accept the next trigger.

A small control state machine sequences the work. A datapath holds three parts: the latched count, an up-counter, and an equality comparator that reports to the controller when the counter reaches the latched count. The timer cannot be retriggered. Trigger edges that arrive while an interval is in progress are dropped. Changing the count input in the middle of an interval has no effect on that interval.

Top module: `oneshot_timer`

## Requirements
- R1: While `rst` is sampled high at a clock edge, and in the cycle after it, `done_o` and `busy_o` are both 0.
- R2: A trigger is accepted when `trig_i` is 1 at an edge where it was 0 at the previous edge and `busy_o` is 0. `busy_o` is 1 in the cycle after that edge.
- R3: If a trigger is accepted at edge E with a count N of 1 or more on `pulse_cnt_i`, `done_o` is high during the N-th cycle after E. The interval is therefore N clock periods long.
- R4: `done_o` stays high for exactly one cycle per interval, and `busy_o` is 0 in the cycle that follows it.
- R5: Trigger edges that arrive while `busy_o` is 1 are ignored. They neither lengthen the interval nor start another one.
- R6: The count is captured at the accepting edge. Any later change on `pulse_cnt_i` leaves the running interval unchanged.
- R7: If `trig_i` is held high for many cycles, only one interval starts. A new rising edge is needed to start another.
- R8: A count of 0 behaves as a count of 1, so `done_o` rises in the first cycle after the accepting edge.
- R9: A trigger edge that is present in the cycle where `done_o` is high is ignored. A rising edge in the following cycle is accepted.
- R10: `busy_o` is 1 in every cycle from the one after the accepting edge up to and including the `done_o` cycle, and `done_o` is never 1 while `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Start request; its rising edge starts an interval |
| pulse_cnt_i | input | 24 | Interval length in clock cycles (0 is treated as 1) |
| done_o | output | 1 | One-cycle completion strobe |
| busy_o | output | 1 | High while an interval is in progress |

## Verification
Two events can land in the same cycle: the end of an interval, and a fresh trigger edge. The bench provokes this on purpose by placing a one-cycle trigger pulse in the exact cycle where `done_o` is due. It then places a second pulse in the very next cycle. A behavioural model predicts the outcome: the first pulse must be lost, and the second must start a new interval with its own full length. `done_o` and `busy_o` are compared with the model in every cycle, so a design that accepts the early pulse, or misses the later one, shows up as a mismatch.

// File: rtl/oneshot_timer_pkg.sv
package oneshot_timer_pkg;

    localparam int unsigned CNT_W_DEF = 24;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_t;

    typedef struct packed {
        logic load;
        logic run;
    } dp_ctrl_t;

    function automatic logic rise_of(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/trig_edge.sv
module trig_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_i;
    end

    assign rise_o = oneshot_timer_pkg::rise_of(level_i, prev_q);
endmodule

// File: rtl/eq_compare.sv
module eq_compare #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         eq_o
);
    logic [W-1:0] bit_eq;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_eq[i] = ~(a_i[i] ^ b_i[i]);
    end

    assign eq_o = &bit_eq;
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath #(
    parameter int unsigned CNT_W = oneshot_timer_pkg::CNT_W_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  oneshot_timer_pkg::dp_ctrl_t ctrl_i,
    input  logic [CNT_W-1:0]            count_i,
    output logic                        match_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] target_q;
    logic [CNT_W-1:0] ticks_q;
    logic             hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= '0;
        end else if (ctrl_i.load) begin
            target_q <= (count_i == '0) ? ONE : count_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ticks_q <= '0;
        end else if (ctrl_i.load) begin
            ticks_q <= ONE;
        end else if (ctrl_i.run) begin
            ticks_q <= hit ? '0 : ticks_q + ONE;
        end
    end

    eq_compare #(.W(CNT_W)) u_cmp (
        .a_i  (ticks_q),
        .b_i  (target_q),
        .eq_o (hit)
    );

    assign match_o = hit;
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic                        match_i,
    output oneshot_timer_pkg::dp_ctrl_t ctrl_o,
    output logic                        done_o,
    output logic                        busy_o
);
    import oneshot_timer_pkg::*;

    tmr_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (match_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign ctrl_o.load = (state_q == ST_IDLE) && start_i;
    assign ctrl_o.run  = (state_q == ST_RUN);
    assign done_o      = (state_q == ST_RUN) && match_i;
    assign busy_o      = (state_q == ST_RUN);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int unsigned CNT_W = oneshot_timer_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] pulse_cnt_i,
    output logic             done_o,
    output logic             busy_o
);
    import oneshot_timer_pkg::*;

    logic     start;
    logic     match;
    dp_ctrl_t dp_ctrl;

    trig_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (trig_i),
        .rise_o  (start)
    );

    timer_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .match_i (match),
        .ctrl_o  (dp_ctrl),
        .done_o  (done_o),
        .busy_o  (busy_o)
    );

    timer_datapath #(.CNT_W(CNT_W)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .ctrl_i  (dp_ctrl),
        .count_i (pulse_cnt_i),
        .match_o (match)
    );
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk (
    input logic clk,
    input logic rst,
    input logic trig_i,
    input logic done_o,
    input logic busy_o
);
    logic trig_prev_q;

    always_ff @(posedge clk) begin
        if (rst) trig_prev_q <= 1'b0;
        else     trig_prev_q <= trig_i;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && trig_i && !trig_prev_q) |=> busy_o);

    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    p_held_trig_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !(trig_i && !trig_prev_q)) |=> !busy_o);

    p_done_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);
endmodule

bind oneshot_timer oneshot_timer_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .trig_i (trig_i),
    .done_o (done_o),
    .busy_o (busy_o)
);

// File: tb/tb_oneshot_timer.sv
module tb_oneshot_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_i = 1'b0;
    logic [23:0] pulse_cnt_i = '0;
    logic        done_o;
    logic        busy_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // behavioural model state
    bit m_busy = 0;
    bit m_prev = 0;
    int m_left = 0;
    int done_seen = 0;

    always #2.5 clk = ~clk;

    oneshot_timer dut (
        .clk         (clk),
        .rst         (rst),
        .trig_i      (trig_i),
        .pulse_cnt_i (pulse_cnt_i),
        .done_o      (done_o),
        .busy_o      (busy_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_prev = 0; m_left = 0;
        end else begin
            if (m_busy) begin
                if (m_left == 1) m_busy = 0;
                else m_left = m_left - 1;
            end else if (trig_i && !m_prev) begin
                m_busy = 1;
                m_left = (pulse_cnt_i == 0) ? 1 : int'(pulse_cnt_i);
            end
            m_prev = trig_i;
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare with the model every cycle, away from the edge
    always @(negedge clk) begin
        check(cur_req, busy_o, m_busy, "busy_o");
        check(cur_req, done_o, m_busy && m_left == 1, "done_o");
        if (done_o === 1'b1) done_seen++;
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic [23:0] pc);
        @(negedge clk); trig_i = 1'b1; pulse_cnt_i = pc;
        @(negedge clk); trig_i = 1'b0;
    endtask

    // measure cycles from accepting edge to done cycle
    task automatic run_len(input string req, input logic [23:0] pc, input int exp_n);
        int n;
        pulse(pc);
        n = 1;
        while (done_o !== 1'b1 && n < 1000) begin
            @(negedge clk); n++;
        end
        checks++;
        if (n != exp_n) begin
            errors++;
            $display("FAIL %s interval: actual %0d expected %0d", req, n, exp_n);
        end
        step(2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int d0;
        cur_req = "R1";
        step(3);
        check("R1", busy_o, 1'b0, "busy_o in reset");
        check("R1", done_o, 1'b0, "done_o in reset");
        @(negedge clk); rst = 1'b0;
        step(2);

        cur_req = "R3";
        run_len("R3", 24'd5, 5);
        run_len("R3", 24'd1, 1);
        run_len("R3", 24'd200, 200);
        cur_req = "R8";
        run_len("R8", 24'd0, 1);

        cur_req = "R2";
        pulse(24'd3);
        check("R2", busy_o, 1'b1, "busy after accept");
        step(4);

        cur_req = "R5";
        d0 = done_seen;
        pulse(24'd10);
        step(2); trig_i = 1'b1; step(1); trig_i = 1'b0; step(2);
        trig_i = 1'b1; step(1); trig_i = 1'b0;
        step(15);
        checks++;
        if (done_seen - d0 != 1) begin
            errors++;
            $display("FAIL R5 done count: actual %0d expected 1", done_seen - d0);
        end

        cur_req = "R6";
        pulse(24'd6);
        pulse_cnt_i = 24'd2; step(1); pulse_cnt_i = 24'd40;
        step(10);

        cur_req = "R7";
        d0 = done_seen;
        @(negedge clk); trig_i = 1'b1; pulse_cnt_i = 24'd2;
        step(12);
        trig_i = 1'b0; step(2);
        checks++;
        if (done_seen - d0 != 1) begin
            errors++;
            $display("FAIL R7 done count: actual %0d expected 1", done_seen - d0);
        end

        cur_req = "R9";
        pulse(24'd4);           // accepted; done in 4th cycle after edge
        step(2);                // now in cycle 3
        trig_i = 1'b1;          // present in done cycle
        step(1);
        check("R9", done_o, 1'b1, "done cycle reached");
        trig_i = 1'b0; step(1); // low sampled in first idle cycle
        check("R9", busy_o, 1'b0, "trigger in done cycle ignored");
        trig_i = 1'b1; step(1); trig_i = 1'b0;
        check("R9", busy_o, 1'b1, "next rise accepted");
        step(6);

        cur_req = "R4";
        run_len("R4", 24'd7, 7);
        cur_req = "R10";
        run_len("R10", 24'd2, 2);

        cur_req = "R1";
        pulse(24'd50);
        step(3);
        @(negedge clk); rst = 1'b1;
        step(1);
        check("R1", busy_o, 1'b0, "busy cleared by reset");
        @(negedge clk); rst = 1'b0;
        step(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule